// File: doc/BRIEF.md
# Alternating Two-Channel Edge Timestamp Capture

This block records when edges occur on one input pin. A free-running timebase counts clock cycles from reset. Two capture channels take turns: when the armed channel sees its chosen edge, the current timebase value goes into that channel's four-entry FIFO, and the other channel is armed next. Software reads the oldest timestamp of each channel by pulsing a pop strobe, so the interval between two edges is the difference of two queued values.

A 10-bit writable control word holds the arm bit, a one-shot bit, an edge select for each channel, a trigger-source select, an enable for a small rising-edge counter, and a FIFO watermark level. In one-shot mode the block clears its own arm bit once the capture sequence is complete. With the source select set, both channels are triggered by the counter's compare match instead of raw edges, which lets the block timestamp every Nth rising edge. The readback word adds both FIFO fill levels above the control bits.

Top module: `pp_cap_top`

## Requirements
- R1: After reset the readback word is 0, both data outputs are 0, and both watermark and overflow flags are 0.
- R2: Each channel's 2-bit edge select means 0 = disabled, 1 = falling, 2 = rising, 3 = either edge. A transition of sig_i sampled at clock edge k is stored at edge k+2, and the stored value is the timebase count before that edge; the timebase is 0 at reset and adds 1 on every edge.
- R3: While the arm bit is 0 no channel stores anything.
- R4: Any control write makes channel 0 the armed channel. With both channels enabled, a capture on channel 0 hands the arm to channel 1; at most one channel captures per cycle.
- R5: Without one-shot, a capture on channel 1 hands the arm back to channel 0 indefinitely; with only one channel enabled, that channel keeps capturing.
- R6: With one-shot, the block clears the arm bit after the channel 1 capture (both enabled) or after the single capture (one enabled), and nothing more is stored until it is armed again.
- R7: When the source select bit is 1, both channels trigger on the edge counter match regardless of edge type; a channel still captures only if its edge select is nonzero.
- R8: The edge counter counts rising edges of the synchronized input and produces a match on every Nth rising edge, N being cmp_i, then restarts from 0; with its enable bit 0 it is held at 0 and gives no match.
- R9: Each channel FIFO holds 4 timestamps returned oldest first; pop_i removes the oldest entry; an empty FIFO outputs 0 and ignores pop.
- R10: A capture into a full FIFO is discarded and sets that channel's overflow flag, which stays set until reset.
- R11: A channel's watermark flag is 1 exactly while its fill level is greater than the 2-bit watermark field.
- R12: Readback layout: bit 0 arm, bit 1 one-shot, bits 3:2 channel 0 edge select, bits 5:4 channel 1 edge select, bit 6 source select, bit 7 counter enable, bits 9:8 watermark, bits 12:10 channel 0 fill, bits 15:13 channel 1 fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | 1 | Raw pin to timestamp, asynchronous |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 10 | Control word write data |
| cmp_i | input | 16 | Edge counter compare value |
| pop_i | input | 2 | Per-channel FIFO pop strobe |
| ctrl_rdata_o | output | 16 | Control and fill-level readback |
| cap0_data_o | output | 16 | Oldest channel 0 timestamp |
| cap1_data_o | output | 16 | Oldest channel 1 timestamp |
| wm_o | output | 2 | Per-channel watermark flag |
| ovf_o | output | 2 | Per-channel sticky overflow flag |

## Verification
A wrong armed-channel pointer shows up on the very next qualifying edge as a fill level growing on the wrong channel, visible in the readback one cycle after the capture edge. A missed one-shot disarm leaves bit 0 of the readback set on the cycle after the final capture, and an off-by-one in the synchronizer or timebase shows as a stored timestamp differing by one from the expected cycle count. Because every output is compared against a cycle-level model on every clock, any FIFO pointer or counter slip is reported within one cycle of the state it corrupts reaching a port.

// File: rtl/pp_cap_pkg.sv
package pp_cap_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  // field order fixes the readback bit positions (MSB first)
  typedef struct packed {
    logic [1:0] wm;
    logic       cnt_en;
    logic       src_cnt;
    edge_sel_e  sel1;
    edge_sel_e  sel0;
    logic       one_shot;
    logic       arm;
  } cap_ctrl_t;

  localparam int unsigned CTRL_W = $bits(cap_ctrl_t);

endpackage

// File: rtl/pp_sync_edge.sv
module pp_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);

  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= sig_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;

endmodule

// File: rtl/pp_edge_cnt.sv
module pp_edge_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          rise_i,
  input  logic [CW-1:0] cmp_i,
  output logic          hit_o
);

  logic [CW-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_q + CW'(1);
  assign hit_o   = en_i & rise_i & (cnt_nxt == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= '0;
    else if (hit_o)     cnt_q <= '0;
    else if (rise_i)    cnt_q <= cnt_nxt;
  end

  AST_CNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0); // R8
  AST_HIT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cnt_q == '0); // R8

endmodule

// File: rtl/pp_cap_fifo.sv
module pp_cap_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] count_q;
  logic          ovf_q;
  logic          full, empty, do_push, do_pop;

  assign full    = count_q == CW'(DEPTH);
  assign empty   = count_q == '0;
  assign do_push = push_i & ~full;
  assign do_pop  = pop_i & ~empty;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (do_push) wr_q <= inc(wr_q);
      if (do_pop)  rd_q <= inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  assign dout_o  = empty ? '0 : mem_q[rd_q];
  assign count_o = count_q;
  assign ovf_o   = ovf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH)); // R10
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && count_q == CW'(DEPTH)) |=> (count_q == CW'(DEPTH) && ovf_q)); // R10
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q); // R10
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && pop_i && !push_i) |=> count_q == '0); // R9

endmodule

// File: rtl/pp_cap_seq.sv
module pp_cap_seq
  import pp_cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic [1:0]        trig_i,
  output cap_ctrl_t         ctrl_o,
  output logic [1:0]        push_o
);

  cap_ctrl_t ctrl_q;
  logic      cur_q;   // 0: channel 0 holds the arm, 1: channel 1
  logic      en0, en1, both, done;

  always_comb begin
    en0       = ctrl_q.sel0 != EDGE_OFF;
    en1       = ctrl_q.sel1 != EDGE_OFF;
    both      = en0 & en1;
    push_o[0] = ctrl_q.arm & en0 & (~both | ~cur_q) & trig_i[0];
    push_o[1] = ctrl_q.arm & en1 & (~both |  cur_q) & trig_i[1];
    done      = ctrl_q.one_shot & (both ? push_o[1] : |push_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cur_q  <= 1'b0;
    end else if (we_i) begin
      ctrl_q <= cap_ctrl_t'(wdata_i);
      cur_q  <= 1'b0;
    end else begin
      if (both && |push_o) cur_q <= push_o[0];
      if (done) ctrl_q.arm <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;

  AST_ONE_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push_o)); // R4
  AST_PING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o[0] && both && !we_i) |=> cur_q); // R4
  AST_PONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o[1] && both && !we_i) |=> !cur_q); // R5
  AST_WRITE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !cur_q); // R4
  AST_ONESHOT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !we_i) |=> !ctrl_q.arm); // R6

endmodule

// File: rtl/pp_cap_top.sv
module pp_cap_top
  import pp_cap_pkg::*;
#(
  parameter int unsigned TW    = 16,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sig_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic [CNT_W-1:0]  cmp_i,
  input  logic [1:0]        pop_i,
  output logic [15:0]       ctrl_rdata_o,
  output logic [TW-1:0]     cap0_data_o,
  output logic [TW-1:0]     cap1_data_o,
  output logic [1:0]        wm_o,
  output logic [1:0]        ovf_o
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  cap_ctrl_t     ctrl;
  logic          rise, fall, cmp_hit;
  logic [1:0]    trig, push;
  logic [TW-1:0] tb_q;
  logic [TW-1:0] dout [2];
  logic [CW-1:0] cnt  [2];
  logic [7:0]    cnt_ext [2];
  edge_sel_e     sel [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tb_q <= '0;
    else         tb_q <= tb_q + TW'(1);
  end

  pp_sync_edge i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  pp_edge_cnt #(.CW(CNT_W)) i_ecnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl.cnt_en),
    .rise_i (rise),
    .cmp_i  (cmp_i),
    .hit_o  (cmp_hit)
  );

  pp_cap_seq i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .trig_i  (trig),
    .ctrl_o  (ctrl),
    .push_o  (push)
  );

  assign sel[0] = ctrl.sel0;
  assign sel[1] = ctrl.sel1;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    always_comb begin
      if (ctrl.src_cnt) trig[c] = cmp_hit;
      else begin
        unique case (sel[c])
          EDGE_FALL: trig[c] = fall;
          EDGE_RISE: trig[c] = rise;
          EDGE_ANY:  trig[c] = rise | fall;
          default:   trig[c] = 1'b0;
        endcase
      end
    end

    pp_cap_fifo #(.DEPTH(DEPTH), .DW(TW)) i_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[c]),
      .din_i   (tb_q),
      .pop_i   (pop_i[c]),
      .dout_o  (dout[c]),
      .count_o (cnt[c]),
      .ovf_o   (ovf_o[c])
    );

    assign wm_o[c]    = cnt[c] > CW'(ctrl.wm);
    assign cnt_ext[c] = 8'(cnt[c]);
  end

  assign cap0_data_o  = dout[0];
  assign cap1_data_o  = dout[1];
  assign ctrl_rdata_o = {cnt_ext[1][2:0], cnt_ext[0][2:0], ctrl};

  AST_DISARMED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_rdata_o[0] && !ctrl_we_i) |=> $stable(ctrl_rdata_o[15:10]) || |$past(pop_i)); // R3

endmodule

// File: tb/test_pp_cap_top.sv
module test_pp_cap_top;
  localparam int unsigned TW = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sig = 1'b0;
  logic        we = 1'b0;
  logic [9:0]  wdata = '0;
  logic [15:0] cmp = 16'd3;
  logic [1:0]  pop = 2'b00;
  logic [15:0] rdata;
  logic [15:0] d0, d1;
  logic [1:0]  wm, ovf;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pp_cap_top i_pp_cap_top (
    .clk_i(clk), .rst_ni(rst_ni), .sig_i(sig), .ctrl_we_i(we),
    .ctrl_wdata_i(wdata), .cmp_i(cmp), .pop_i(pop),
    .ctrl_rdata_o(rdata), .cap0_data_o(d0), .cap1_data_o(d1),
    .wm_o(wm), .ovf_o(ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- reference model ----------------
  logic [15:0] q0[$], q1[$];
  logic [9:0]  m_ctrl;
  logic        m_cur, m_s1, m_s2, m_s3;
  logic [1:0]  m_ovf;
  logic [15:0] m_tb, m_cnt;

  function automatic bit fires(input logic [1:0] s, input bit r, input bit f);
    return (s == 2'd1 && f) || (s == 2'd2 && r) || (s == 2'd3 && (r || f));
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q0.delete(); q1.delete();
      m_ctrl = '0; m_cur = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_ovf = '0; m_tb = '0; m_cnt = '0;
    end else begin
      bit r, f, hit, t0, t1, e0, e1, p0, p1, fin, f0, f1;
      r = m_s2 && !m_s3;
      f = !m_s2 && m_s3;
      hit = m_ctrl[7] && r && (16'(m_cnt + 1) == cmp);
      t0 = m_ctrl[6] ? hit : fires(m_ctrl[3:2], r, f);
      t1 = m_ctrl[6] ? hit : fires(m_ctrl[5:4], r, f);
      e0 = m_ctrl[3:2] != 0;
      e1 = m_ctrl[5:4] != 0;
      p0 = m_ctrl[0] && e0 && t0 && (!e1 || !m_cur);
      p1 = m_ctrl[0] && e1 && t1 && (!e0 || m_cur);
      fin = m_ctrl[1] && ((e0 && e1) ? p1 : (p0 || p1));
      f0 = q0.size() == 4;
      f1 = q1.size() == 4;
      if (pop[0] && q0.size() > 0) void'(q0.pop_front());
      if (pop[1] && q1.size() > 0) void'(q1.pop_front());
      if (p0) begin if (f0) m_ovf[0] = 1; else q0.push_back(m_tb); end
      if (p1) begin if (f1) m_ovf[1] = 1; else q1.push_back(m_tb); end
      if (we) begin
        m_ctrl = wdata; m_cur = 0;
      end else begin
        if (e0 && e1 && p0) m_cur = 1;
        if (e0 && e1 && p1) m_cur = 0;
        if (fin) m_ctrl[0] = 0;
      end
      if (!m_ctrl_en_prev(hit)) m_cnt = '0;
      else if (hit) m_cnt = '0;
      else if (r) m_cnt = m_cnt + 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sig;
      m_tb = m_tb + 1;
    end
  end

  // counter enable as seen before this edge's control write
  logic m_en_snap;
  always @(negedge clk) m_en_snap = m_ctrl[7];
  function automatic bit m_ctrl_en_prev(input bit unused_hit);
    return m_en_snap || (unused_hit && 1'b0);
  endfunction

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      cyc++;
      chk("R12", rdata, {3'(q1.size()), 3'(q0.size()), m_ctrl});
      chk("R9 ch0 data", d0, q0.size() > 0 ? q0[0] : 16'h0);
      chk("R9 ch1 data", d1, q1.size() > 0 ? q1[0] : 16'h0);
      chk("R11", wm, {2'(q1.size() > m_ctrl[9:8]), 2'(q0.size() > m_ctrl[9:8])} & 2'b11 == 2'b11 ?
          {q1.size() > m_ctrl[9:8], q0.size() > m_ctrl[9:8]} : {q1.size() > m_ctrl[9:8], q0.size() > m_ctrl[9:8]});
      chk("R10", ovf, m_ovf);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [9:0] v);
    @(negedge clk); we = 1; wdata = v;
    @(negedge clk); we = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sig = 1;
      repeat (4) @(negedge clk);
      sig = 0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic drain();
    @(negedge clk); pop = 2'b11;
    repeat (5) @(negedge clk);
    pop = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 data", {d1, d0}, 0);
    chk("R1 flags", {wm, ovf}, 0);
    rst_ni = 1;
    // R3 disarmed: rising selected on both, arm 0
    wr(10'h028);
    pulses(2);
    chk("R3 no capture", rdata[15:10], 0);
    // R4/R5 free-running both rising, falls ignored (R2)
    wr(10'h029);
    pulses(4);
    chk("R4 ch0 count", rdata[12:10], 2);
    chk("R5 ch1 count", rdata[15:13], 2);
    chk("R5 still armed", rdata[0], 1);
    drain();
    // R2/R5 single channel falling, continuous
    wr(10'h005);
    pulses(3);
    chk("R2 ch0 falls", rdata[12:10], 3);
    chk("R5 ch1 idle", rdata[15:13], 0);
    drain();
    // R6 one-shot both channels, either edge
    wr(10'h03F);
    pulses(3);
    chk("R6 ch0 one", rdata[12:10], 1);
    chk("R6 ch1 one", rdata[15:13], 1);
    chk("R6 arm cleared", rdata[0], 0);
    drain();
    // R6 one-shot single channel 1 rising
    wr(10'h023);
    pulses(2);
    chk("R6 single ch1", rdata[15:13], 1);
    chk("R6 single arm", rdata[0], 0);
    drain();
    // R10/R11 overflow and watermark 3 on channel 0
    wr(10'h309);
    chk("R12 layout", rdata[9:0], 10'h309);
    pulses(6);
    chk("R10 full", rdata[12:10], 4);
    chk("R10 ovf", ovf, 2'b01);
    chk("R11 above", wm[0], 1);
    @(negedge clk); pop = 2'b01; @(negedge clk); pop = 2'b00;
    @(negedge clk);
    chk("R11 at level", wm[0], 0);
    drain();
    // R7/R8 counter source, every 3rd rising, edge type ignored
    cmp = 16'd3;
    wr(10'h0D5);
    pulses(6);
    chk("R7 ch0 count", rdata[12:10], 1);
    chk("R8 ch1 count", rdata[15:13], 1);
    drain();
    // R8 counter disabled: no matches
    wr(10'h055);
    pulses(6);
    chk("R8 held", rdata[15:10], 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule